// File: doc/BRIEF.md
# Code Verify Scrambler and Lock Guard

This block stands between the on-chip program store and any path that reads it back from outside the chip. Each verify read takes the code byte fetched from the array, picks one entry from a 64-byte scramble table using the low six bits of the read address, and returns the bitwise XNOR of the two. The table starts all ones, and while it stays that way the code byte comes back unchanged. The block also answers the three fixed identification reads.

Three lock bits set one of four protection levels, and each level adds to the one below it. The block decodes the level into permission outputs for the rest of the chip:

- gating of table-lookup fetches from internal memory when those fetches are made by code running from external memory;
- holding of the external-access strap at its value sampled during reset;
- a programming inhibit;
- a verify inhibit;
- an external-execution inhibit.

In programming mode, write strobes can clear bits in the scramble table and in the lock bits. Bits can only be cleared, never set again.

Top module: `cvl_guard`

## Requirements
- R1: After power-on reset (`por_n` low), every table entry is 0xFF and all three lock bits are 1. A verify read therefore returns the code byte unchanged, and the outputs `movc_ext_block`, `prog_inhibit`, `verify_inhibit` and `ext_exec_inhibit` are all 0.
- R2: A read (`rd_en` high, `rd_sig` low) sampled at a clock edge sets `rd_valid` after that edge. If no inhibit applies, `rd_data` then equals `~(code_in ^ table[rd_addr[5:0]])`. `rd_valid` is low after any edge where `rd_en` was low.
- R3: A code byte of 0xFF returns the selected table entry itself.
- R4: A table write (`prog_wr` high, `prog_lock` low) replaces entry `prog_idx` with `entry & prog_data`. Ones in `prog_data` leave bits unchanged. The new value is seen by reads from the next edge on.
- R5: A lock write (`prog_wr` high, `prog_lock` high) clears lock bits where `prog_data[2:0]` holds zeros. Bit 0 is the first lock bit, bit 1 the second, bit 2 the third, and a 0 means the bit is programmed. Lock bits can never return to 1, and lock writes are accepted at every level.
- R6: Lock pattern 3'b110 is level 2. It raises `movc_ext_block` and `prog_inhibit`, holds the access strap, and causes table writes to be ignored.
- R7: Lock pattern 3'b100 is level 3. It adds `verify_inhibit`, and every verify read then returns 0xFF.
- R8: Lock pattern 3'b000 is level 4. It adds `ext_exec_inhibit`.
- R9: Any lock pattern other than 3'b111, 3'b110, 3'b100 and 3'b000 behaves exactly as level 4.
- R10: A signature read (`rd_en` and `rd_sig` high) returns 0x89 at address 0x30, 0x58 at 0x31, `DEV_CODE` at 0x60 (default 0xF2) and 0xFF at any other address. The result does not depend on the lock level.
- R11: Whenever `core_rst` is high at a clock edge, the block latches `ea_pin`; the latch is 1 after power-on. At level 1, `ea_eff` follows `ea_pin` directly. At levels 2 to 4, `ea_eff` shows the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; restores the unprogrammed state |
| core_rst | input | 1 | Device reset, active high; the access strap is sampled while it is high |
| ea_pin | input | 1 | External-access strap from the pin |
| prog_wr | input | 1 | Programming write strobe |
| prog_lock | input | 1 | 1 selects the lock bits, 0 selects the scramble table |
| prog_idx | input | KEY_IDX_W | Table entry index for a programming write |
| prog_data | input | DATA_W | Write data; zeros clear bits |
| rd_en | input | 1 | Read request |
| rd_sig | input | 1 | 1 requests a signature read, 0 a verify read |
| rd_addr | input | ADDR_W | Read address |
| code_in | input | DATA_W | Code byte from the program array |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read result |
| movc_ext_block | output | 1 | Blocks internal table fetches issued from external code |
| ea_eff | output | 1 | Effective external-access strap |
| prog_inhibit | output | 1 | Further array programming disabled |
| verify_inhibit | output | 1 | Verify readout disabled |
| ext_exec_inhibit | output | 1 | External execution disabled |

## Verification
A wrong table entry stays hidden until a read selects that index. It then shows up one cycle later as flipped bits in `rd_data`, and most clearly with a 0xFF code byte, which exposes the entry directly. A wrong lock bit shows on the permission outputs at the edge after the write. A bit that sets itself again, or an undefined pattern decoded too leniently, appears as a level lower than the pattern that was written. A broken strap latch stays invisible until a level of 2 or higher is active and `ea_pin` changes after `core_rst` falls.

// File: rtl/cvl_pkg.sv
package cvl_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN     = 2'd0,
        LVL_FETCH    = 2'd1,
        LVL_NOVERIFY = 2'd2,
        LVL_SEALED   = 2'd3
    } lock_lvl_e;

    typedef struct packed {
        logic movc_block;
        logic prog_block;
        logic verify_block;
        logic exec_block;
        logic ea_hold;
    } perm_t;

    localparam int LOCK_BITS = 3;

endpackage

// File: rtl/cvl_key_table.sv
module cvl_key_table #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_key
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = mem_q[wr_idx] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_key = mem_q[rd_idx];

    // R4: an entry never gains a one bit
    p_key_clear_only_r4: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((mem_q[$past(wr_idx)] & ~$past(mem_q[wr_idx])) == '0));

endmodule

// File: rtl/cvl_lock_ctrl.sv
module cvl_lock_ctrl
    import cvl_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 core_rst,
    input  logic                 ea_pin,
    input  logic                 lb_wr,
    input  logic [LOCK_BITS-1:0] lb_clr,
    output perm_t                perm,
    output logic                 ea_eff
);

    typedef struct packed {
        logic [LOCK_BITS-1:0] lb;
        logic                 ea;
    } lock_st_t;

    lock_st_t  st_d, st_q;
    lock_lvl_e lvl;

    always_comb begin
        st_d = st_q;
        if (lb_wr) begin
            st_d.lb = st_q.lb & lb_clr;
        end
        if (core_rst) begin
            st_d.ea = ea_pin;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{lb: '1, ea: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.lb)
            3'b111:  lvl = LVL_OPEN;
            3'b110:  lvl = LVL_FETCH;
            3'b100:  lvl = LVL_NOVERIFY;
            default: lvl = LVL_SEALED;
        endcase
        perm.movc_block   = (lvl != LVL_OPEN);
        perm.prog_block   = (lvl != LVL_OPEN);
        perm.ea_hold      = (lvl != LVL_OPEN);
        perm.verify_block = (lvl == LVL_NOVERIFY) || (lvl == LVL_SEALED);
        perm.exec_block   = (lvl == LVL_SEALED);
    end

    assign ea_eff = perm.ea_hold ? st_q.ea : ea_pin;

    // R5: lock bits only ever clear
    p_lock_clear_only_r5: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((st_q.lb & ~$past(st_q.lb)) == '0));

    // R8: each level includes the protections of the one below
    p_level_nest_r8: assert property (@(posedge clk) disable iff (!por_n)
        (perm.exec_block |-> perm.verify_block) and
        (perm.verify_block |-> perm.prog_block) and
        (perm.prog_block |-> perm.movc_block));

    // R11: held strap stays put while not in device reset
    p_ea_hold_r11: assert property (@(posedge clk) disable iff (!por_n)
        (perm.ea_hold && $past(perm.ea_hold) && !$past(core_rst)) |-> (ea_eff == $past(ea_eff)));

endmodule

// File: rtl/cvl_sig_lookup.sv
module cvl_sig_lookup #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [7:0]      DEV_CODE = 8'hF2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] sig_byte
);

    always_comb begin
        sig_byte = '1;
        if (addr == ADDR_W'(16'h0030)) begin
            sig_byte = DATA_W'(8'h89);
        end else if (addr == ADDR_W'(16'h0031)) begin
            sig_byte = DATA_W'(8'h58);
        end else if (addr == ADDR_W'(16'h0060)) begin
            sig_byte = DATA_W'(DEV_CODE);
        end
    end

endmodule

// File: rtl/cvl_guard.sv
module cvl_guard
    import cvl_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 8,
    parameter int         KEY_DEPTH = 64,
    parameter logic [7:0] DEV_CODE  = 8'hF2,
    localparam int        KEY_IDX_W = $clog2(KEY_DEPTH)
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 core_rst,
    input  logic                 ea_pin,
    input  logic                 prog_wr,
    input  logic                 prog_lock,
    input  logic [KEY_IDX_W-1:0] prog_idx,
    input  logic [DATA_W-1:0]    prog_data,
    input  logic                 rd_en,
    input  logic                 rd_sig,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [DATA_W-1:0]    code_in,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 movc_ext_block,
    output logic                 ea_eff,
    output logic                 prog_inhibit,
    output logic                 verify_inhibit,
    output logic                 ext_exec_inhibit
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t            rd_d, rd_q;
    perm_t             perm;
    logic [DATA_W-1:0] key_byte;
    logic [DATA_W-1:0] sig_byte;
    logic              key_wr;

    assign key_wr = prog_wr && !prog_lock && !perm.prog_block;

    cvl_key_table #(
        .DEPTH  (KEY_DEPTH),
        .DATA_W (DATA_W)
    ) u_key (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (key_wr),
        .wr_idx  (prog_idx),
        .wr_data (prog_data),
        .rd_idx  (rd_addr[KEY_IDX_W-1:0]),
        .rd_key  (key_byte)
    );

    cvl_lock_ctrl u_lock (
        .clk      (clk),
        .por_n    (por_n),
        .core_rst (core_rst),
        .ea_pin   (ea_pin),
        .lb_wr    (prog_wr && prog_lock),
        .lb_clr   (prog_data[LOCK_BITS-1:0]),
        .perm     (perm),
        .ea_eff   (ea_eff)
    );

    cvl_sig_lookup #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DEV_CODE (DEV_CODE)
    ) u_sig (
        .addr     (rd_addr),
        .sig_byte (sig_byte)
    );

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) begin
            if (rd_sig) begin
                rd_d.data = sig_byte;
            end else if (perm.verify_block) begin
                rd_d.data = '1;
            end else begin
                rd_d.data = ~(code_in ^ key_byte);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rd_q <= '{valid: 1'b0, data: '1};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid         = rd_q.valid;
    assign rd_data          = rd_q.data;
    assign movc_ext_block   = perm.movc_block;
    assign prog_inhibit     = perm.prog_block;
    assign verify_inhibit   = perm.verify_block;
    assign ext_exec_inhibit = perm.exec_block;

    // R2: every accepted read yields a valid result one edge later
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!por_n)
        rd_en |=> rd_valid);

    // R7: inhibited verify reads come back blank
    p_verify_dark_r7: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && !rd_sig && verify_inhibit) |=> (rd_data == '1));

    // R10: manufacturer signature is fixed
    p_sig_maker_r10: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && rd_sig && rd_addr == ADDR_W'(16'h0030)) |=> (rd_data == DATA_W'(8'h89)));

endmodule

// File: tb/test_cvl_guard.sv
module test_cvl_guard;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [7:0] DEV = 8'hF2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic core_rst = 1'b0;
    logic ea_pin = 1'b1;
    logic prog_wr = 1'b0;
    logic prog_lock = 1'b0;
    logic [5:0] prog_idx = '0;
    logic [DW-1:0] prog_data = '1;
    logic rd_en = 1'b0;
    logic rd_sig = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] code_in = '0;
    logic rd_valid;
    logic [DW-1:0] rd_data;
    logic movc_ext_block, ea_eff, prog_inhibit, verify_inhibit, ext_exec_inhibit;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_key [64];
    logic [2:0] m_lb;
    logic       m_ea;

    always #2 clk = ~clk;

    cvl_guard #(.ADDR_W(AW), .DATA_W(DW), .KEY_DEPTH(64), .DEV_CODE(DEV)) i_cvl_guard (
        .clk(clk), .por_n(por_n), .core_rst(core_rst), .ea_pin(ea_pin),
        .prog_wr(prog_wr), .prog_lock(prog_lock), .prog_idx(prog_idx), .prog_data(prog_data),
        .rd_en(rd_en), .rd_sig(rd_sig), .rd_addr(rd_addr), .code_in(code_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .movc_ext_block(movc_ext_block),
        .ea_eff(ea_eff), .prog_inhibit(prog_inhibit), .verify_inhibit(verify_inhibit),
        .ext_exec_inhibit(ext_exec_inhibit)
    );

    function automatic int lvl_of(input logic [2:0] lb);
        case (lb)
            3'b111:  return 1;
            3'b110:  return 2;
            3'b100:  return 3;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] sig_of(input logic [AW-1:0] a);
        if (a == 16'h0030) return 8'h89;
        if (a == 16'h0031) return 8'h58;
        if (a == 16'h0060) return DEV;
        return 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic power_on();
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        for (int i = 0; i < 64; i++) m_key[i] = 8'hFF;
        m_lb = 3'b111;
        m_ea = 1'b1;
    endtask

    task automatic do_read(input string req, input logic sig, input logic [AW-1:0] a, input logic [7:0] code);
        logic [7:0] exp;
        if (sig) exp = sig_of(a);
        else if (lvl_of(m_lb) >= 3) exp = 8'hFF;
        else exp = ~(code ^ m_key[a[5:0]]);
        @(negedge clk);
        rd_en = 1'b1; rd_sig = sig; rd_addr = a; code_in = code;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid == 1'b1, "R2 rd_valid", 32'(rd_valid), 32'd1);
        chk(rd_data == exp, req, 32'(rd_data), 32'(exp));
    endtask

    task automatic tbl_write(input logic [5:0] idx, input logic [7:0] d);
        @(negedge clk);
        prog_wr = 1'b1; prog_lock = 1'b0; prog_idx = idx; prog_data = d;
        @(negedge clk);
        prog_wr = 1'b0;
        if (lvl_of(m_lb) == 1) m_key[idx] = m_key[idx] & d;
    endtask

    task automatic lock_write(input logic [2:0] clr);
        @(negedge clk);
        prog_wr = 1'b1; prog_lock = 1'b1; prog_data = {5'h1F, clr};
        @(negedge clk);
        prog_wr = 1'b0;
        m_lb = m_lb & clr;
    endtask

    task automatic check_perm(input string req);
        int l;
        logic [3:0] exp, act;
        l = lvl_of(m_lb);
        exp = {l >= 2, l >= 2, l >= 3, l == 4};
        act = {movc_ext_block, prog_inhibit, verify_inhibit, ext_exec_inhibit};
        chk(act == exp, req, 32'(act), 32'(exp));
    endtask

    task automatic strap(input logic rst, input logic pin);
        @(negedge clk);
        core_rst = rst; ea_pin = pin;
        @(negedge clk);
        if (rst) m_ea = pin;
        chk(ea_eff == ((lvl_of(m_lb) >= 2) ? m_ea : ea_pin), "R11 ea_eff",
            32'(ea_eff), 32'((lvl_of(m_lb) >= 2) ? m_ea : ea_pin));
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        power_on();
        // R1 reset state
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        check_perm("R1 permissions after reset");
        do_read("R1 unscrambled verify", 1'b0, 16'h1234, 8'h5A);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R2 rd_valid idle", 32'(rd_valid), 32'd0);

        // R4 / R3 directed
        tbl_write(6'd5, 8'hF0);
        tbl_write(6'd5, 8'h3F);
        do_read("R3 ff code shows entry", 1'b0, 16'h0045, 8'hFF);
        tbl_write(6'd5, 8'hFF);
        do_read("R4 ones do not restore", 1'b0, 16'h0005, 8'hFF);

        // R2 random mix in open level
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[1:0] == 2'd0) tbl_write(6'($urandom()), 8'($urandom()) | 8'($urandom()));
            else if (r[1:0] == 2'd1) do_read("R10 random signature", 1'b1, (r[2] ? 16'h0030 + 16'(r[5:3]) : 16'h0060), 8'($urandom()));
            else do_read("R2 random verify", 1'b0, 16'($urandom()), r[8] ? 8'hFF : 8'($urandom()));
        end

        // R10 directed
        do_read("R10 sig 30", 1'b1, 16'h0030, 8'h00);
        do_read("R10 sig 31", 1'b1, 16'h0031, 8'h00);
        do_read("R10 sig 60", 1'b1, 16'h0060, 8'h00);
        do_read("R10 sig other", 1'b1, 16'h0130, 8'h00);

        // R11 open level follows pin
        strap(1'b0, 1'b0);
        strap(1'b0, 1'b1);
        strap(1'b1, 1'b0);
        strap(1'b0, 1'b1);

        // R6 level 2
        lock_write(3'b110);
        check_perm("R6 level2 permissions");
        tbl_write(6'd9, 8'h00);
        do_read("R6 table write ignored", 1'b0, 16'h0009, 8'hFF);
        do_read("R6 verify still allowed", 1'b0, 16'h0005, 8'hA5);
        strap(1'b1, 1'b0);
        strap(1'b0, 1'b1);
        strap(1'b0, 1'b0);
        strap(1'b1, 1'b1);
        strap(1'b0, 1'b0);

        // R5 clear only: try to set LB1 back
        lock_write(3'b111);
        check_perm("R5 lock bit cannot be set");

        // R7 level 3
        lock_write(3'b101);
        check_perm("R7 level3 permissions");
        do_read("R7 verify blanked", 1'b0, 16'h0005, 8'h00);
        do_read("R10 sig unaffected by lock", 1'b1, 16'h0031, 8'h00);

        // R8 level 4
        lock_write(3'b011);
        check_perm("R8 level4 permissions");
        do_read("R8 verify blanked", 1'b0, 16'h0022, 8'h11);

        // R9 undefined patterns
        power_on();
        check_perm("R1 por restores open");
        lock_write(3'b101);
        check_perm("R9 pattern 101 sealed");
        do_read("R9 verify blanked", 1'b0, 16'h0003, 8'h3C);
        power_on();
        lock_write(3'b011);
        check_perm("R9 pattern 011 sealed");
        power_on();
        lock_write(3'b010);
        check_perm("R9 pattern 010 sealed");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule